// File: doc/BRIEF.md
# DRAM Strobe Decoder

This block is the control side of a DRAM device whose strobes arrive without a clock. A fast internal clock samples the four active-low strobes (row strobe, column strobe, write enable, output enable) and the multiplexed address bus. From the order in which strobe edges appear, it turns each memory cycle into array commands. These commands are row activate, column read, column write and refresh row. It also drives an enable for the data pin drivers.

A falling row strobe normally opens the row on the address bus. If the column strobe fell while the row strobe was still high, and is still low when the row strobe falls, the cycle is a refresh instead. The row then comes from an internal wrapping counter and the address bus is ignored. While a row stays open, each new column strobe fall starts another access in that row. Write enable decides the kind of access: low at that fall means a write with the data pins kept off, high means a read. A read becomes a write if write enable falls later in the access.

Strobes and address each pass through a synchroniser. A command appears as a one-cycle pulse on the third rising clock edge after its triggering pin change.

Top module: `dram_strobe_decoder`

## Requirements
- R1: After reset `cmd_valid` and `dq_oe` are 0, and the first refresh issued uses row 0.
- R2: A row strobe fall that is not a refresh emits one command with `cmd_op` = 1 (activate) and `cmd_row` equal to the address bus at that fall.
- R3: If the column strobe falls while the row strobe is high and is still low when the row strobe falls, one command with `cmd_op` = 4 (refresh) is emitted. Its `cmd_row` is the refresh counter, whatever the address bus holds.
- R4: The refresh counter advances by one after every refresh and wraps from 511 to 0. Access cycles do not change it.
- R5: During a refresh cycle no read or write command is emitted and `dq_oe` stays 0, even with output enable low.
- R6: With a row open, every column strobe fall with write enable high emits `cmd_op` = 2 (read). It carries `cmd_col` equal to the address bus at that fall and `cmd_row` equal to the open row. Several falls under one row strobe give several reads.
- R7: A column strobe fall with write enable already low emits `cmd_op` = 3 (write) with `cmd_late` = 0. `dq_oe` then stays 0 for the rest of that access.
- R8: If write enable falls during a read access, one write command with `cmd_late` = 1 is emitted for the same column, and `dq_oe` drops.
- R9: `dq_oe` is 1 only during a read access, while the column strobe is low, output enable is low and write enable is high. It returns to 0 when the column strobe rises or output enable goes high.
- R10: A column strobe that falls and then rises again before the row strobe falls does not cause a refresh. The cycle is a normal activate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low, asynchronous |
| cas_n | input | 1 | Column strobe, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| addr | input | ADDR_W | Multiplexed row/column address |
| cmd_valid | output | 1 | One-cycle command pulse |
| cmd_op | output | 3 | 1 activate, 2 read, 3 write, 4 refresh |
| cmd_row | output | ADDR_W | Row of the command |
| cmd_col | output | ADDR_W | Column of a read or write |
| cmd_late | output | 1 | Write timed by write enable (1) or by column strobe (0) |
| dq_oe | output | 1 | Data pin driver enable |

## Verification
A corrupted refresh counter appears at the next refresh command as a wrong `cmd_row`. The bench drives 512 consecutive refreshes, so a missed wrap or a double step is caught within one refresh period. A stale arming flag or a wrong open-row register turns an activate into a refresh (or the reverse), or attaches the wrong row to a read. This shows up in the first command after the fault. A read flag left set after a write or a refresh shows at once as a driven `dq_oe` while output enable is low.

// File: rtl/dsd_pkg.sv
package dsd_pkg;

    localparam int CMD_W = 3;

    typedef enum logic [CMD_W-1:0] {
        OP_NONE = 3'd0,
        OP_ACT  = 3'd1,
        OP_RD   = 3'd2,
        OP_WR   = 3'd3,
        OP_REF  = 3'd4
    } cmd_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_OPEN,
        ST_REF
    } cyc_state_e;

    // Sampled strobe levels, all active low.
    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic oe_n;
    } strobe_t;

    localparam int STROBE_W = $bits(strobe_t);

    typedef struct packed {
        logic ras_fall;
        logic ras_rise;
        logic cas_fall;
        logic cas_rise;
        logic we_fall;
    } edges_t;

    function automatic logic fell(input logic prev, input logic cur);
        return prev & ~cur;
    endfunction

endpackage

// File: rtl/dsd_sync.sv
module dsd_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)
                chain[gi] <= RST_VAL;
            else if (gi == 0)
                chain[gi] <= d;
            else
                chain[gi] <= chain[(gi == 0) ? 0 : gi-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/dsd_edges.sv
module dsd_edges
    import dsd_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  strobe_t cur,
    output edges_t  edg
);
    strobe_t prev_q;

    always_ff @(posedge clk) begin
        if (rst)
            prev_q <= '1;
        else
            prev_q <= cur;
    end

    always_comb begin
        edg.ras_fall = fell(prev_q.ras_n, cur.ras_n);
        edg.ras_rise = fell(cur.ras_n, prev_q.ras_n);
        edg.cas_fall = fell(prev_q.cas_n, cur.cas_n);
        edg.cas_rise = fell(cur.cas_n, prev_q.cas_n);
        edg.we_fall  = fell(prev_q.we_n, cur.we_n);
    end
endmodule

// File: rtl/dsd_refcnt.sv
module dsd_refcnt #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (step)
            cnt <= cnt + W'(1);
    end
endmodule

// File: rtl/dram_strobe_decoder.sv
module dram_strobe_decoder
    import dsd_pkg::*;
#(
    parameter int ADDR_W      = 9,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              cmd_valid,
    output logic [CMD_W-1:0]  cmd_op,
    output logic [ADDR_W-1:0] cmd_row,
    output logic [ADDR_W-1:0] cmd_col,
    output logic              cmd_late,
    output logic              dq_oe
);
    localparam int REF_W = ADDR_W;

    typedef struct packed {
        cmd_op_e           op;
        logic [ADDR_W-1:0] row;
        logic [ADDR_W-1:0] col;
        logic              late;
    } cmd_t;

    logic [STROBE_W-1:0] s_vec;
    logic [ADDR_W-1:0]   a_s;
    strobe_t             s;
    edges_t              e;

    dsd_sync #(.W(STROBE_W), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_ssync (
        .clk(clk), .rst(rst), .d({ras_n, cas_n, we_n, oe_n}), .q(s_vec)
    );
    // Address rides the same delay so it lines up with the strobes.
    dsd_sync #(.W(ADDR_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_async (
        .clk(clk), .rst(rst), .d(addr), .q(a_s)
    );

    assign s = strobe_t'(s_vec);

    dsd_edges u_edges (.clk(clk), .rst(rst), .cur(s), .edg(e));

    cyc_state_e        state_q;
    logic              armed_q;
    logic              rd_open_q;
    logic              wr_hiz_q;
    logic [ADDR_W-1:0] row_q;
    logic [ADDR_W-1:0] col_q;
    logic [REF_W-1:0]  ref_cnt;
    logic              ref_step;
    logic              go_ref;
    cmd_t              cmd_q;
    logic              cmd_v_q;

    // Refresh: column strobe fell earlier and is still low now.
    assign go_ref   = (state_q == ST_IDLE) && e.ras_fall && armed_q && !s.cas_n;
    assign ref_step = go_ref;

    dsd_refcnt #(.W(REF_W)) u_refcnt (
        .clk(clk), .rst(rst), .step(ref_step), .cnt(ref_cnt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            armed_q   <= 1'b0;
            rd_open_q <= 1'b0;
            wr_hiz_q  <= 1'b0;
            row_q     <= '0;
            col_q     <= '0;
            cmd_q     <= '0;
            cmd_v_q   <= 1'b0;
        end else begin
            cmd_v_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (e.ras_fall) begin
                        armed_q <= 1'b0;
                        cmd_v_q <= 1'b1;
                        if (go_ref) begin
                            state_q <= ST_REF;
                            cmd_q   <= '{op: OP_REF, row: ref_cnt, col: '0, late: 1'b0};
                        end else begin
                            state_q <= ST_OPEN;
                            row_q   <= a_s;
                            cmd_q   <= '{op: OP_ACT, row: a_s, col: '0, late: 1'b0};
                        end
                    end else if (e.cas_fall) begin
                        armed_q <= 1'b1;
                    end else if (e.cas_rise) begin
                        armed_q <= 1'b0;
                    end
                end
                ST_OPEN: begin
                    if (e.ras_rise) begin
                        state_q   <= ST_IDLE;
                        rd_open_q <= 1'b0;
                        wr_hiz_q  <= 1'b0;
                    end else if (e.cas_fall) begin
                        col_q   <= a_s;
                        cmd_v_q <= 1'b1;
                        if (!s.we_n) begin
                            cmd_q     <= '{op: OP_WR, row: row_q, col: a_s, late: 1'b0};
                            wr_hiz_q  <= 1'b1;
                            rd_open_q <= 1'b0;
                        end else begin
                            cmd_q     <= '{op: OP_RD, row: row_q, col: a_s, late: 1'b0};
                            wr_hiz_q  <= 1'b0;
                            rd_open_q <= 1'b1;
                        end
                    end else if (e.cas_rise) begin
                        rd_open_q <= 1'b0;
                        wr_hiz_q  <= 1'b0;
                    end else if (e.we_fall && rd_open_q && !s.cas_n) begin
                        cmd_v_q   <= 1'b1;
                        cmd_q     <= '{op: OP_WR, row: row_q, col: col_q, late: 1'b1};
                        rd_open_q <= 1'b0;
                    end
                end
                ST_REF: begin
                    if (e.ras_rise)
                        state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign dq_oe     = (state_q == ST_OPEN) && rd_open_q && !s.cas_n && !s.oe_n && s.we_n;
    assign cmd_valid = cmd_v_q;
    assign cmd_op    = cmd_q.op;
    assign cmd_row   = cmd_q.row;
    assign cmd_col   = cmd_q.col;
    assign cmd_late  = cmd_q.late;
endmodule

// File: rtl/dsd_checker.sv
module dsd_checker
    import dsd_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_valid,
    input logic [CMD_W-1:0]  cmd_op,
    input logic [ADDR_W-1:0] cmd_row,
    input logic              cmd_late,
    input logic              dq_oe,
    input logic              in_ref,
    input logic              in_open,
    input logic              wr_hiz,
    input logic              ref_step,
    input logic [ADDR_W-1:0] ref_cnt
);
    logic [ADDR_W-1:0] act_row_q;
    logic              have_row_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_row_q  <= '0;
            have_row_q <= 1'b0;
        end else if (cmd_valid && cmd_op == OP_ACT) begin
            act_row_q  <= cmd_row;
            have_row_q <= 1'b1;
        end
    end

    assert_cmd_code_R2: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (cmd_op >= 3'd1 && cmd_op <= 3'd4));

    assert_counter_step_R4: assert property (@(posedge clk) disable iff (rst)
        ref_step |=> ref_cnt == ADDR_W'($past(ref_cnt) + 1));

    assert_refresh_hiz_R5: assert property (@(posedge clk) disable iff (rst)
        in_ref |-> !dq_oe);

    assert_page_row_R6: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && (cmd_op == OP_RD || cmd_op == OP_WR)) |-> (have_row_q && cmd_row == act_row_q));

    assert_early_write_hiz_R7: assert property (@(posedge clk) disable iff (rst)
        wr_hiz |-> !dq_oe);

    assert_late_is_write_R8: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_late) |-> cmd_op == OP_WR);

    assert_oe_in_open_row_R9: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> in_open);
endmodule

bind dram_strobe_decoder dsd_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_row(cmd_row), .cmd_late(cmd_late), .dq_oe(dq_oe),
    .in_ref(state_q == dsd_pkg::ST_REF), .in_open(state_q == dsd_pkg::ST_OPEN),
    .wr_hiz(wr_hiz_q), .ref_step(ref_step), .ref_cnt(ref_cnt)
);

// File: tb/sim_dram_strobe_decoder.sv
module sim_dram_strobe_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 9;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic cmd_valid, cmd_late, dq_oe;
    logic [2:0] cmd_op;
    logic [AW-1:0] cmd_row, cmd_col;

    always #(CLK_PERIOD/2) clk = ~clk;

    dram_strobe_decoder #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_row(cmd_row),
        .cmd_col(cmd_col), .cmd_late(cmd_late), .dq_oe(dq_oe)
    );

    typedef struct {
        int    op;
        int    row;
        int    col;
        bit    late;
        string tag;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int fails = 0;
    int ref_row = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push(input int op, input int row, input int col, input bit late, input string tag);
        exp_t x;
        x.op = op; x.row = row; x.col = col; x.late = late; x.tag = tag;
        q.push_back(x);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pops one expected command per pulse.
    always @(negedge clk) begin
        if (!rst && cmd_valid) begin
            if (q.size() == 0) begin
                chk(1'b0, "R5 unexpected command", int'(cmd_op), 0);
            end else begin
                exp_t x;
                x = q.pop_front();
                chk(int'(cmd_op) == x.op, {x.tag, " op"}, int'(cmd_op), x.op);
                chk(int'(cmd_row) == x.row, {x.tag, " row"}, int'(cmd_row), x.row);
                if (x.op == 2 || x.op == 3) begin
                    chk(int'(cmd_col) == x.col, {x.tag, " col"}, int'(cmd_col), x.col);
                    chk(cmd_late == x.late, {x.tag, " late"}, int'(cmd_late), int'(x.late));
                end
            end
        end
    end

    task automatic open_row(input int row, input string tag);
        addr = AW'(row); tick(3);
        push(1, row, 0, 1'b0, tag);
        ras_n = 1'b0; tick(6);
    endtask

    task automatic col_read(input int row, input int col, input string tag);
        addr = AW'(col); tick(3);
        push(2, row, col, 1'b0, tag);
        cas_n = 1'b0; tick(6);
    endtask

    task automatic end_col();
        cas_n = 1'b1; we_n = 1'b1; tick(5);
    endtask

    task automatic close_row();
        cas_n = 1'b1; we_n = 1'b1; tick(4);
        ras_n = 1'b1; tick(6);
    endtask

    task automatic cbr(input string tag);
        cas_n = 1'b0; tick(4);
        addr = AW'(9'h1FF - ref_row);
        push(4, ref_row, 0, 1'b0, tag);
        ras_n = 1'b0; tick(6);
        ras_n = 1'b1; cas_n = 1'b1; tick(5);
        ref_row = (ref_row + 1) % 512;
    endtask

    initial begin
        tick(3);
        rst = 1'b0;
        tick(2);
        // R1: reset state
        chk(cmd_valid == 1'b0, "R1 cmd_valid after reset", int'(cmd_valid), 0);
        chk(dq_oe == 1'b0, "R1 dq_oe after reset", int'(dq_oe), 0);

        // R2, R6, R9: open row, page reads
        open_row(9'h1A5, "R2 activate");
        oe_n = 1'b0;
        col_read(9'h1A5, 9'h033, "R6 read col");
        chk(dq_oe == 1'b1, "R9 oe on read", int'(dq_oe), 1);
        end_col();
        chk(dq_oe == 1'b0, "R9 oe off on cas rise", int'(dq_oe), 0);
        col_read(9'h1A5, 9'h100, "R6 page read second");
        chk(dq_oe == 1'b1, "R9 oe on page read", int'(dq_oe), 1);
        oe_n = 1'b1; tick(4);
        chk(dq_oe == 1'b0, "R9 oe off with oe_n high", int'(dq_oe), 0);
        oe_n = 1'b0; end_col();

        // R7: early write keeps pins off
        addr = 9'h055; we_n = 1'b0; tick(3);
        push(3, 9'h1A5, 9'h055, 1'b0, "R7 early write");
        cas_n = 1'b0; tick(6);
        chk(dq_oe == 1'b0, "R7 pins off in early write", int'(dq_oe), 0);
        end_col();

        // R8: late write during a read access
        col_read(9'h1A5, 9'h077, "R8 read before late write");
        chk(dq_oe == 1'b1, "R8 oe on before late write", int'(dq_oe), 1);
        push(3, 9'h1A5, 9'h077, 1'b1, "R8 late write");
        we_n = 1'b0; tick(6);
        chk(dq_oe == 1'b0, "R8 oe off after late write", int'(dq_oe), 0);
        close_row();

        // R1, R3, R5: first refresh uses row 0, ignores addr, pins stay off
        cas_n = 1'b0; tick(4);
        addr = 9'h1FF;
        push(4, 0, 0, 1'b0, "R3 first refresh row");
        ras_n = 1'b0; tick(6);
        chk(dq_oe == 1'b0, "R5 pins off in refresh", int'(dq_oe), 0);
        we_n = 1'b0; tick(4);
        chk(dq_oe == 1'b0, "R5 pins still off in refresh", int'(dq_oe), 0);
        ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; tick(5);
        ref_row = 1;

        // R10: CAS pulse that ends before RAS falls gives an activate
        cas_n = 1'b0; tick(4);
        cas_n = 1'b1; tick(4);
        open_row(9'h0C3, "R10 activate after cas pulse");
        col_read(9'h0C3, 9'h011, "R6 read after R10");
        close_row();

        // R4: run the counter through its wrap
        for (int i = 1; i < 512; i++) cbr("R4 refresh sequence");
        chk(ref_row == 0, "R4 bench count wrapped", ref_row, 0);
        cbr("R4 wrap to row 0");
        open_row(9'h002, "R4 access between refreshes");
        close_row();
        cbr("R4 row 1 after access");

        tick(5);
        chk(q.size() == 0, "R2 all expected commands seen", q.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule